// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Arbiter

This block sits next to a processor's instruction sequencer and decides which exception is taken at the next instruction boundary. It watches a wide set of peripheral interrupt flags, each with its own enable bit. Groups of flag/enable pairs are folded into numbered hardware sources, so one vector can serve several events. The block also sees a global interrupt mask and a software-interrupt request. When the sequencer signals an instruction boundary, the arbiter picks the single most urgent exception and issues a one-cycle grant that carries the 16-bit address of that exception's vector.

The order of urgency is fixed. A pending reset fetch comes first. It is armed by the block's own reset and taken at the first boundary afterwards. The software interrupt comes next and ignores the global mask. Hardware sources follow in numeric order, with source 1 the most urgent and the last source the least. Vector addresses run downward in 2-byte steps from the reset vector, so the position of an exception in the order also fixes its vector. A registered per-source status word shows which hardware sources are pending, whatever the mask says.

The arbiter never clears a flag. A source that loses arbitration, or that wins, stays pending until its peripheral drops the flag. The picker can be built as a scan chain or as a lowest-set-bit isolator. The choice is a parameter and does not change the behaviour.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While reset is asserted, grant_o is 0, status_o is all zero and vector_o holds 16'hFFFE. The first cycle with boundary_i high after reset is released grants vector 16'hFFFE, whatever the other inputs are. After that, the reset vector is not issued again until the next reset.
- R2: When several exceptions are eligible at one boundary, exactly one is granted. The order is: the pending reset fetch, then the software interrupt, then hardware source 1, 2, and so on up to source NUM_SRC.
- R3: The software interrupt uses vector 16'hFFFC. Hardware source n (1..16) uses vector 16'hFFFC − 2·n, so source 1 uses 16'hFFFA and source 16 uses 16'hFFDC.
- R4: Hardware source n is pending when any of its FLAGS_PER_SRC flags is set together with the enable bit at the same position. Flag j of source n sits at bit (n−1)·FLAGS_PER_SRC + j of flag_i and en_i, with FLAGS_PER_SRC = 5.
- R5: A flag whose enable bit is 0 has no effect on grants or on status_o.
- R6: A grant appears only in the cycle after a clock edge at which boundary_i was high, and lasts exactly one cycle per such edge. Between grants, vector_o keeps its last value.
- R7: While imask_i is 1 at the boundary, no hardware source is granted.
- R8: swi_req_i is granted at a boundary even when imask_i is 1, unless a reset fetch is still pending.
- R9: Bit n−1 of status_o equals the pending state of source n one clock earlier. It does not depend on imask_i or boundary_i.
- R10: A grant does not clear any pending state. A source still pending at the next boundary is arbitrated again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; arms the reset-vector fetch |
| flag_i | input | NUM_SRC·FLAGS_PER_SRC (80) | Peripheral interrupt flags, grouped per source |
| en_i | input | NUM_SRC·FLAGS_PER_SRC (80) | Enable bit for each flag, same layout as flag_i |
| imask_i | input | 1 | Global mask; 1 blocks hardware sources |
| swi_req_i | input | 1 | Software-interrupt request, not maskable |
| boundary_i | input | 1 | High in the last cycle of the current instruction |
| grant_o | output | 1 | One-cycle pulse: an exception was selected |
| vector_o | output | VEC_W (16) | Vector address of the selected exception |
| status_o | output | NUM_SRC (16) | Registered pending state, bit n−1 for source n |

## Verification
On every cycle the assertions check the following. A grant follows a boundary. A granted hardware vector never follows a set mask. A software request at a boundary is always granted with its own vector. The reset fetch wins the first boundary. Every granted vector is even and lies in range. The picker's winner is pending and has no more urgent pending neighbour. Only the bench scenarios can show the full mapping from each source number to its exact address, and the folding of each shared flag into its source. They also show that a disabled flag stays invisible, that losers are granted in turn once the winner's flag clears, and that the status word tracks pending state with one cycle of delay.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      GK_NONE  = 2'd0,
      GK_RESET = 2'd1,
      GK_SWI   = 2'd2,
      GK_HW    = 2'd3
   } grant_kind_e;

   localparam int unsigned PICK_CHAIN  = 0;
   localparam int unsigned PICK_ISOLATE = 1;

   // Address of hardware source (zero-based index idx) below the software vector.
   function automatic int unsigned hw_vector(input int unsigned swi_vec,
                                             input int unsigned step,
                                             input int unsigned idx);
      return swi_vec - step * (idx + 1);
   endfunction

endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
   parameter int unsigned NUM_SRC        = 16,
   parameter int unsigned FLAGS_PER_SRC  = 5,
   localparam int unsigned FLAG_W        = NUM_SRC * FLAGS_PER_SRC
) (
   input  logic [FLAG_W-1:0]  flag_i,
   input  logic [FLAG_W-1:0]  en_i,
   output logic [NUM_SRC-1:0] pend_o
);

   if (FLAGS_PER_SRC < 1) begin : g_bad_fps
      $error("irq_src_merge: FLAGS_PER_SRC must be at least 1");
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [FLAGS_PER_SRC-1:0] gated;
      assign gated     = flag_i[s*FLAGS_PER_SRC +: FLAGS_PER_SRC]
                       & en_i[s*FLAGS_PER_SRC +: FLAGS_PER_SRC];
      assign pend_o[s] = |gated;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_SRC   = 16,
   parameter int unsigned PICK_IMPL = irq_arb_pkg::PICK_CHAIN,
   localparam int unsigned IDX_W    = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   output logic               valid_o,
   output logic [IDX_W-1:0]   idx_o
);

   if (NUM_SRC < 2) begin : g_bad_num
      $error("irq_prio_pick: NUM_SRC must be at least 2");
   end

   assign valid_o = |req_i;

   if (PICK_IMPL == irq_arb_pkg::PICK_CHAIN) begin : g_chain
      // Scan from least to most urgent; the last hit (lowest index) wins.
      always_comb begin
         idx_o = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
         end
      end
   end else if (PICK_IMPL == irq_arb_pkg::PICK_ISOLATE) begin : g_isolate
      logic [NUM_SRC-1:0] lowest;
      assign lowest = req_i & (~req_i + NUM_SRC'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (lowest[i]) idx_o = idx_o | IDX_W'(i);
         end
      end
   end else begin : g_bad_impl
      $error("irq_prio_pick: unknown PICK_IMPL");
   end

   // R2
   winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> req_i[idx_o]);

   // R2
   winner_most_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ((req_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0));

endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
   parameter int unsigned NUM_SRC  = 16,
   parameter int unsigned VEC_W    = 16,
   parameter int unsigned TOP_VEC  = 'hFFFE,
   parameter int unsigned VEC_STEP = 2,
   localparam int unsigned IDX_W   = $clog2(NUM_SRC),
   localparam int unsigned SWI_VEC = TOP_VEC - VEC_STEP
) (
   input  logic                     rst_pend_i,
   input  logic                     swi_req_i,
   input  logic                     imask_i,
   input  logic                     hw_valid_i,
   input  logic [IDX_W-1:0]         hw_idx_i,
   output irq_arb_pkg::grant_kind_e kind_o,
   output logic [VEC_W-1:0]         vec_o
);
   import irq_arb_pkg::*;

   if (TOP_VEC < VEC_STEP * (NUM_SRC + 1)) begin : g_bad_range
      $error("irq_vec_sel: vector table would wrap below zero");
   end
   if (TOP_VEC >= (64'd1 << VEC_W)) begin : g_bad_width
      $error("irq_vec_sel: TOP_VEC does not fit in VEC_W bits");
   end

   logic [VEC_W-1:0] hw_vec;
   assign hw_vec = VEC_W'(hw_vector(SWI_VEC, VEC_STEP, 32'(hw_idx_i)));

   always_comb begin
      if (rst_pend_i)                    kind_o = GK_RESET;
      else if (swi_req_i)                kind_o = GK_SWI;
      else if (hw_valid_i && !imask_i)   kind_o = GK_HW;
      else                               kind_o = GK_NONE;
   end

   always_comb begin
      unique case (kind_o)
         GK_RESET: vec_o = VEC_W'(TOP_VEC);
         GK_SWI:   vec_o = VEC_W'(SWI_VEC);
         GK_HW:    vec_o = hw_vec;
         default:  vec_o = VEC_W'(TOP_VEC);
      endcase
   end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
   parameter int unsigned NUM_SRC       = 16,
   parameter int unsigned FLAGS_PER_SRC = 5,
   parameter int unsigned VEC_W         = 16,
   parameter int unsigned TOP_VEC       = 'hFFFE,
   parameter int unsigned VEC_STEP      = 2,
   parameter int unsigned PICK_IMPL     = irq_arb_pkg::PICK_CHAIN,
   localparam int unsigned FLAG_W       = NUM_SRC * FLAGS_PER_SRC,
   localparam int unsigned IDX_W        = $clog2(NUM_SRC),
   localparam int unsigned SWI_VEC      = TOP_VEC - VEC_STEP,
   localparam int unsigned LOW_VEC      = SWI_VEC - VEC_STEP * NUM_SRC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FLAG_W-1:0]  flag_i,
   input  logic [FLAG_W-1:0]  en_i,
   input  logic               imask_i,
   input  logic               swi_req_i,
   input  logic               boundary_i,
   output logic               grant_o,
   output logic [VEC_W-1:0]   vector_o,
   output logic [NUM_SRC-1:0] status_o
);
   import irq_arb_pkg::*;

   if (VEC_STEP == 0 || (VEC_STEP % 2) != 0) begin : g_bad_step
      $error("irq_vector_arbiter: VEC_STEP must be a non-zero even number");
   end

   logic [NUM_SRC-1:0] pend;
   logic               hw_valid;
   logic [IDX_W-1:0]   hw_idx;
   grant_kind_e        kind;
   logic [VEC_W-1:0]   sel_vec;
   logic               rst_pend_q;

   irq_src_merge #(
      .NUM_SRC       (NUM_SRC),
      .FLAGS_PER_SRC (FLAGS_PER_SRC)
   ) i_merge (
      .flag_i (flag_i),
      .en_i   (en_i),
      .pend_o (pend)
   );

   irq_prio_pick #(
      .NUM_SRC   (NUM_SRC),
      .PICK_IMPL (PICK_IMPL)
   ) i_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (pend),
      .valid_o (hw_valid),
      .idx_o   (hw_idx)
   );

   irq_vec_sel #(
      .NUM_SRC  (NUM_SRC),
      .VEC_W    (VEC_W),
      .TOP_VEC  (TOP_VEC),
      .VEC_STEP (VEC_STEP)
   ) i_sel (
      .rst_pend_i (rst_pend_q),
      .swi_req_i  (swi_req_i),
      .imask_i    (imask_i),
      .hw_valid_i (hw_valid),
      .hw_idx_i   (hw_idx),
      .kind_o     (kind),
      .vec_o      (sel_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pend_q <= 1'b1;
         grant_o    <= 1'b0;
         vector_o   <= VEC_W'(TOP_VEC);
         status_o   <= '0;
      end else begin
         status_o <= pend;
         grant_o  <= 1'b0;
         if (boundary_i && kind != GK_NONE) begin
            grant_o  <= 1'b1;
            vector_o <= sel_vec;
            if (kind == GK_RESET) rst_pend_q <= 1'b0;
         end
      end
   end

   // R6
   grant_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> $past(boundary_i));

   // R7
   masked_hw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && vector_o < VEC_W'(SWI_VEC)) |-> !$past(imask_i));

   // R8
   swi_unmaskable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(boundary_i && swi_req_i && !rst_pend_q)
         |-> (grant_o && vector_o == VEC_W'(SWI_VEC)));

   // R1
   reset_fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(boundary_i && rst_pend_q) |-> (grant_o && vector_o == VEC_W'(TOP_VEC)));

   // R3
   vector_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> (vector_o >= VEC_W'(LOW_VEC) && vector_o <= VEC_W'(TOP_VEC)
                   && !vector_o[0]));

endmodule

// File: tb/test_irq_vector_arbiter.sv
module test_irq_vector_arbiter;
   localparam int NS = 16;
   localparam int FP = 5;
   localparam int FW = NS * FP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [FW-1:0] flag_i = '0;
   logic [FW-1:0] en_i = '0;
   logic          imask_i = 1'b0;
   logic          swi_req_i = 1'b0;
   logic          boundary_i = 1'b0;
   logic          grant_o;
   logic [15:0]   vector_o;
   logic [NS-1:0] status_o;

   int n_checks = 0;
   int n_fail = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   irq_vector_arbiter i_irq_vector_arbiter (
      .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i),
      .imask_i(imask_i), .swi_req_i(swi_req_i), .boundary_i(boundary_i),
      .grant_o(grant_o), .vector_o(vector_o), .status_o(status_o)
   );

   // Behavioural reference model
   logic          m_grant;
   logic [15:0]   m_vec;
   logic [NS-1:0] m_status;
   bit            m_rst;

   always @(posedge clk or negedge rst_n) begin : model
      int win;
      bit p [NS];
      if (!rst_n) begin
         m_grant = 0; m_vec = 16'hFFFE; m_status = '0; m_rst = 1;
      end else begin
         win = -1;
         for (int n = 0; n < NS; n++) begin
            p[n] = 0;
            for (int j = 0; j < FP; j++)
               if (flag_i[n*FP+j] && en_i[n*FP+j]) p[n] = 1;
         end
         for (int n = NS - 1; n >= 0; n--) if (p[n]) win = n;
         m_grant = 0;
         if (boundary_i) begin
            if (m_rst) begin m_grant = 1; m_vec = 16'hFFFE; m_rst = 0; end
            else if (swi_req_i) begin m_grant = 1; m_vec = 16'hFFFC; end
            else if (!imask_i && win >= 0) begin
               m_grant = 1; m_vec = 16'(32'hFFFC - 2 * (win + 1));
            end
         end
         for (int n = 0; n < NS; n++) m_status[n] = p[n];
      end
   end

   task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Per-clock comparison against the model
   always @(negedge clk) begin
      chk({cur_req, " grant"}, grant_o === m_grant, 32'(grant_o), 32'(m_grant));
      chk({cur_req, " vector"}, vector_o === m_vec, 32'(vector_o), 32'(m_vec));
      chk({cur_req, " status"}, status_o === m_status, 32'(status_o), 32'(m_status));
   end

   task automatic set_src(int n, int j, bit f, bit e);
      flag_i[(n-1)*FP+j] = f;
      en_i[(n-1)*FP+j] = e;
   endtask

   task automatic clear_all();
      flag_i = '0; en_i = '0; imask_i = 0; swi_req_i = 0;
   endtask

   task automatic fire(string tag, logic [15:0] exp);
      boundary_i = 1;
      @(negedge clk);
      chk(tag, grant_o === 1'b1 && vector_o === exp, {15'd0, grant_o, vector_o}, {16'd1, exp});
      boundary_i = 0;
   endtask

   task automatic nofire(string tag);
      boundary_i = 1;
      @(negedge clk);
      chk(tag, grant_o === 1'b0, 32'(grant_o), 32'd0);
      boundary_i = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      // R1: reset state and first fetch
      cur_req = "R1";
      repeat (3) @(negedge clk);
      chk("R1 reset grant", grant_o === 1'b0, 32'(grant_o), 0);
      chk("R1 reset status", status_o === '0, 32'(status_o), 0);
      chk("R1 reset vector", vector_o === 16'hFFFE, 32'(vector_o), 32'hFFFE);
      rst_n = 1;
      @(negedge clk);
      swi_req_i = 1; set_src(1, 0, 1, 1);
      fire("R1 reset fetch beats SWI (R2)", 16'hFFFE);
      cur_req = "R2";
      fire("R2 SWI beats source 1", 16'hFFFC);
      clear_all();
      @(negedge clk);

      // R3: every source vector
      cur_req = "R3";
      for (int n = 1; n <= NS; n++) begin
         clear_all();
         set_src(n, n % FP, 1, 1);
         fire("R3 source vector", 16'(32'hFFFC - 2 * n));
      end
      clear_all();
      set_src(16, 4, 1, 1);
      fire("R3 lowest source", 16'hFFDC);
      clear_all();
      set_src(1, 2, 1, 1);
      fire("R3 source 1", 16'hFFFA);

      // R2 / R10: priority and losers stay pending
      cur_req = "R2";
      clear_all();
      set_src(5, 0, 1, 1); set_src(9, 3, 1, 1); set_src(14, 1, 1, 1);
      fire("R2 source 5 wins", 16'hFFF2);
      cur_req = "R10";
      fire("R10 source 5 again", 16'hFFF2);
      set_src(5, 0, 0, 1);
      fire("R10 source 9 next", 16'hFFEA);
      set_src(9, 3, 0, 1);
      fire("R10 source 14 next", 16'hFFE0);

      // R4: every flag of a shared vector
      cur_req = "R4";
      for (int j = 0; j < FP; j++) begin
         clear_all();
         set_src(12, j, 1, 1);
         fire("R4 shared flag", 16'hFFE4);
      end

      // R5: disabled flag ignored
      cur_req = "R5";
      clear_all();
      set_src(3, 2, 1, 0); set_src(3, 0, 0, 1);
      nofire("R5 disabled flag no grant");
      chk("R5 disabled flag status", status_o[2] === 1'b0, 32'(status_o), 0);

      // R6: boundary qualification and single pulse
      cur_req = "R6";
      clear_all();
      set_src(7, 1, 1, 1);
      repeat (3) begin
         @(negedge clk);
         chk("R6 no boundary no grant", grant_o === 1'b0, 32'(grant_o), 0);
      end
      fire("R6 grant at boundary", 16'hFFEE);
      @(negedge clk);
      chk("R6 one-cycle pulse", grant_o === 1'b0, 32'(grant_o), 0);
      chk("R6 vector holds", vector_o === 16'hFFEE, 32'(vector_o), 32'hFFEE);

      // R7 / R8 / R9: mask
      cur_req = "R7";
      clear_all();
      imask_i = 1; set_src(2, 4, 1, 1);
      nofire("R7 masked hardware");
      chk("R9 status ignores mask", status_o[1] === 1'b1, 32'(status_o), 32'h2);
      cur_req = "R8";
      swi_req_i = 1;
      fire("R8 SWI under mask", 16'hFFFC);
      swi_req_i = 0; imask_i = 0;
      cur_req = "R7";
      fire("R7 unmasked source 2", 16'hFFF8);

      // R9: random traffic against the model
      cur_req = "R9";
      for (int c = 0; c < 600; c++) begin
         @(negedge clk);
         flag_i = {16'($urandom), $urandom, $urandom} & {16'($urandom), $urandom, $urandom};
         en_i = {16'($urandom), $urandom, $urandom};
         imask_i = ($urandom % 4) == 0;
         swi_req_i = ($urandom % 8) == 0;
         boundary_i = ($urandom % 3) == 0;
      end
      @(negedge clk);
      boundary_i = 0;
      clear_all();
      repeat (2) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule